// File: doc/BRIEF.md
# Branch Target Stream Buffer

This block is a small fully associative store that the fetch stage searches on every cycle. Each entry is tagged with the address of a branch that was executed before. It holds that branch's target address and a short run of instruction words starting at the target. When the current fetch address matches a stored tag, the block returns the target address and the stored instruction words in the same cycle. Fetch can then keep going past a taken branch without waiting for instruction memory.

On a miss the normal fetch path proceeds. When execute later resolves the branch as taken, it drives the update port with the branch address, the target and the instruction words found there. The block then rewrites the entry that already holds that tag. If no entry holds it, the block fills the lowest free entry, or evicts one in round-robin order once every entry is in use.

Top module: `branch_stream_buffer`

## Requirements
- R1: After reset no entry is valid, so `fetch_hit` is 0 for every fetch address, including address 0.
- R2: Lookup is combinational. When `fetch_addr` equals the tag of a valid entry, `fetch_hit` is 1 and `fetch_target` carries that entry's target address in the same cycle.
- R3: On a miss, `fetch_hit`, `fetch_target` and `fetch_instr` are all zero.
- R4: An update presented with `upd_en` high at a clock edge can be looked up from the following cycle.
- R5: An update whose `upd_branch_pc` is already stored overwrites that entry in place. No other entry is lost.
- R6: While any entry is free, a new tag goes into a free entry and nothing is evicted. Eight distinct tags all stay resident.
- R7: When all entries are full, a new tag evicts entries in round-robin order. The pointer starts at entry 0 after reset and advances only when an eviction happens.
- R8: A lookup and an update to the same tag in the same cycle return the old contents. The new contents are returned from the next cycle on.
- R9: Instruction word k (k = 0 for the target instruction itself) is stored from `upd_instr[32k +: 32]` and returned on `fetch_instr[32k +: 32]`, for k = 0, 1, 2.
- R10: No two valid entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_addr | input | 32 | Address of the current fetch |
| fetch_hit | output | 1 | A valid entry matches `fetch_addr` |
| fetch_target | output | 32 | Target address of the matching entry |
| fetch_instr | output | 96 | Three stored instruction words, target instruction in bits 31:0 |
| upd_en | input | 1 | Install or refresh an entry at this clock edge |
| upd_branch_pc | input | 32 | Address of the resolved taken branch (tag) |
| upd_target | input | 32 | Resolved target address |
| upd_instr | input | 96 | Instruction words at the target, word 0 in bits 31:0 |

## Verification
Lookup results are due in the same cycle as the fetch address. The bench therefore drives `fetch_addr` at the falling edge and samples one nanosecond later, well before the next rising edge. An update takes effect at the rising edge that sees `upd_en`, and its effect is due from the cycle after that edge. Each check that depends on an update is made only after that edge, once the following falling edge has passed. The same-cycle case samples once before the committing edge to see the old contents, and once after it to see the new contents. The bench never infers eviction order from internal state: it reads eviction order only from which tags stop hitting.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  // Why a write lands in the slot it does
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_INPLACE = 2'd1,
    WR_FREE    = 2'd2,
    WR_EVICT   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/bsb_store.sv
module bsb_store #(
  parameter int ENTRIES = 8,
  parameter int AW      = 32,
  parameter int DW      = 128,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDXW-1:0]               wr_idx,
  input  logic [AW-1:0]                 wr_tag,
  input  logic [DW-1:0]                 wr_data,
  output logic [ENTRIES-1:0]            valid_o,
  output logic [ENTRIES-1:0][AW-1:0]    tag_o,
  output logic [ENTRIES-1:0][DW-1:0]    data_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_o[g] <= 1'b0;
        tag_o[g]   <= '0;
        data_o[g]  <= '0;
      end else if (slot_we) begin
        valid_o[g] <= 1'b1;
        tag_o[g]   <= wr_tag;
        data_o[g]  <= wr_data;
      end
    end
  end
endmodule

// File: rtl/bsb_match.sv
module bsb_match #(
  parameter int ENTRIES = 8,
  parameter int AW      = 32
) (
  input  logic [AW-1:0]               key,
  input  logic [ENTRIES-1:0]          valid,
  input  logic [ENTRIES-1:0][AW-1:0]  tags,
  output logic [ENTRIES-1:0]          match_vec,
  output logic                        any_match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid[g] && (tags[g] == key);
  end
  assign any_match = |match_vec;
endmodule

// File: rtl/bsb_victim.sv
module bsb_victim
  import bsb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [ENTRIES-1:0] upd_match,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDXW-1:0]    wr_idx,
  output wr_kind_e           wr_kind,
  output logic [IDXW-1:0]    rr_ptr
);
  function automatic logic [IDXW-1:0] onehot_to_idx(input logic [ENTRIES-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) if (v[i]) r = r | IDXW'(i);
    return r;
  endfunction

  function automatic logic [IDXW-1:0] lowest_free(input logic [ENTRIES-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!v[i]) r = IDXW'(i);
    return r;
  endfunction

  function automatic logic [IDXW-1:0] rr_next(input logic [IDXW-1:0] p);
    return (p == IDXW'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_kind = WR_NONE;
    wr_idx  = '0;
    if (req) begin
      if (|upd_match) begin
        wr_kind = WR_INPLACE;
        wr_idx  = onehot_to_idx(upd_match);
      end else if (!(&valid)) begin
        wr_kind = WR_FREE;
        wr_idx  = lowest_free(valid);
      end else begin
        wr_kind = WR_EVICT;
        wr_idx  = rr_ptr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rr_ptr <= '0;
    else if (wr_kind == WR_EVICT) rr_ptr <= rr_next(rr_ptr);
  end
endmodule

// File: rtl/branch_stream_buffer.sv
module branch_stream_buffer
  import bsb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 32,
  parameter int IW      = 32,
  parameter int WORDS   = 3,
  localparam int IDXW   = $clog2(ENTRIES),
  localparam int SW     = WORDS * IW,
  localparam int DW     = AW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_hit,
  output logic [AW-1:0] fetch_target,
  output logic [SW-1:0] fetch_instr,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_branch_pc,
  input  logic [AW-1:0] upd_target,
  input  logic [SW-1:0] upd_instr
);
  logic [ENTRIES-1:0]           valid_q;
  logic [ENTRIES-1:0][AW-1:0]   tag_q;
  logic [ENTRIES-1:0][DW-1:0]   data_q;
  logic [ENTRIES-1:0]           fetch_match;
  logic [ENTRIES-1:0]           upd_match;
  logic                         upd_hit;
  logic [IDXW-1:0]              wr_idx;
  wr_kind_e                     wr_kind;
  logic [IDXW-1:0]              rr_ptr;
  logic [DW-1:0]                hit_data;

  // Entry layout: target address low, instruction words above it
  function automatic logic [DW-1:0] pack_entry(input logic [AW-1:0] t, input logic [SW-1:0] s);
    return {s, t};
  endfunction

  function automatic logic [DW-1:0] select_entry(input logic [ENTRIES-1:0] m,
                                                 input logic [ENTRIES-1:0][DW-1:0] d);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) if (m[i]) r = r | d[i];
    return r;
  endfunction

  bsb_store #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_kind != WR_NONE), .wr_idx(wr_idx),
    .wr_tag(upd_branch_pc), .wr_data(pack_entry(upd_target, upd_instr)),
    .valid_o(valid_q), .tag_o(tag_q), .data_o(data_q)
  );

  bsb_match #(.ENTRIES(ENTRIES), .AW(AW)) u_fetch_cmp (
    .key(fetch_addr), .valid(valid_q), .tags(tag_q),
    .match_vec(fetch_match), .any_match(fetch_hit)
  );

  bsb_match #(.ENTRIES(ENTRIES), .AW(AW)) u_upd_cmp (
    .key(upd_branch_pc), .valid(valid_q), .tags(tag_q),
    .match_vec(upd_match), .any_match(upd_hit)
  );

  bsb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .req(upd_en),
    .upd_match(upd_match), .valid(valid_q),
    .wr_idx(wr_idx), .wr_kind(wr_kind), .rr_ptr(rr_ptr)
  );

  assign hit_data     = select_entry(fetch_match, data_q);
  assign fetch_target = hit_data[AW-1:0];
  assign fetch_instr  = hit_data[DW-1:AW];

  // R10
  dup_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_match) && $onehot0(upd_match));

  // R4
  install_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(upd_branch_pc)));

  // R5
  inplace_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_hit) |=> ($countones(valid_q) == $past($countones(valid_q))));

  // R7
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind != WR_EVICT) |=> $stable(rr_ptr));

  // R6
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_hit && !(&valid_q)) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));
endmodule

// File: tb/branch_stream_buffer_bench.sv
`timescale 1ns/1ps
module branch_stream_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_hit;
  logic [31:0] fetch_target;
  logic [95:0] fetch_instr;
  logic        upd_en = 1'b0;
  logic [31:0] upd_branch_pc = '0;
  logic [31:0] upd_target = '0;
  logic [95:0] upd_instr = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  branch_stream_buffer u_branch_stream_buffer (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_hit(fetch_hit),
    .fetch_target(fetch_target), .fetch_instr(fetch_instr), .upd_en(upd_en),
    .upd_branch_pc(upd_branch_pc), .upd_target(upd_target), .upd_instr(upd_instr)
  );

  function automatic logic [31:0] pc_of(input int n);
    return 32'h0000_4000 + 32'(n) * 32'h24;
  endfunction
  function automatic logic [31:0] tgt_of(input logic [31:0] pc, input int gen);
    return (pc ^ 32'h0A50_0000) + 32'(gen) * 32'h100;
  endfunction
  function automatic logic [95:0] ins_of(input logic [31:0] pc, input int gen);
    logic [95:0] r;
    for (int k = 0; k < 3; k++) r[32*k +: 32] = {pc[15:0], 8'(gen), 8'(k + 1)};
    return r;
  endfunction

  task automatic put(input logic [31:0] pc, input int gen);
    @(negedge clk);
    upd_en = 1'b1; upd_branch_pc = pc;
    upd_target = tgt_of(pc, gen); upd_instr = ins_of(pc, gen);
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic eh, input logic [31:0] et,
                      input logic [95:0] ei, input string req);
    fetch_addr = a;
    #1;
    checks++;
    if (fetch_hit !== eh || fetch_target !== et || fetch_instr !== ei) begin
      errors++;
      $display("FAIL %s addr=%h hit=%b/%b target=%h/%h instr=%h/%h", req, a,
               fetch_hit, eh, fetch_target, et, fetch_instr, ei);
    end
  endtask

  task automatic expect_entry(input int n, input int gen, input string req);
    look(pc_of(n), 1'b1, tgt_of(pc_of(n), gen), ins_of(pc_of(n), gen), req);
  endtask
  task automatic expect_miss(input logic [31:0] a, input string req);
    look(a, 1'b0, '0, '0, req);
  endtask

  task automatic t_reset_state;
    expect_miss(32'h0, "R1 addr0");
    expect_miss(pc_of(0), "R1 pc0");
    expect_miss(32'hFFFF_FFFF, "R1 ones");
  endtask

  task automatic t_single_install;
    put(pc_of(0), 0);
    expect_entry(0, 0, "R4 R2 install visible");
    checks++;
    if (fetch_instr[31:0] !== {pc_of(0)[15:0], 8'd0, 8'd1} ||
        fetch_instr[95:64] !== {pc_of(0)[15:0], 8'd0, 8'd3}) begin
      errors++;
      $display("FAIL R9 word order instr=%h", fetch_instr);
    end
    expect_miss(pc_of(0) + 32'h4, "R3 neighbour miss");
  endtask

  task automatic t_fill;
    for (int n = 1; n < 8; n++) put(pc_of(n), 0);
    for (int n = 0; n < 8; n++) expect_entry(n, 0, "R6 all eight resident");
  endtask

  task automatic t_evict;
    put(pc_of(8), 0);
    expect_miss(pc_of(0), "R7 first eviction slot0");
    for (int n = 1; n < 9; n++) expect_entry(n, 0, "R7 survivors after first");
    put(pc_of(9), 0);
    expect_miss(pc_of(1), "R7 second eviction slot1");
    expect_entry(2, 0, "R7 slot2 kept");
  endtask

  task automatic t_inplace;
    put(pc_of(5), 1);
    expect_entry(5, 1, "R5 overwritten");
    for (int n = 2; n < 10; n++) if (n != 5) expect_entry(n, 0, "R5 nothing lost");
    put(pc_of(10), 0);
    expect_miss(pc_of(2), "R7 pointer held by in-place write");
    expect_entry(3, 0, "R7 slot3 kept");
    expect_entry(10, 0, "R7 new tag resident");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    upd_en = 1'b1; upd_branch_pc = pc_of(3);
    upd_target = tgt_of(pc_of(3), 2); upd_instr = ins_of(pc_of(3), 2);
    expect_entry(3, 0, "R8 old contents same cycle");
    @(negedge clk);
    upd_en = 1'b0;
    expect_entry(3, 2, "R8 new contents next cycle");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_single_install();
    t_fill();
    t_evict();
    t_inplace();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule